// File: doc/BRIEF.md
# SDRAM Mode Register Write Decoder

This block listens on the internal write bus of a memory controller and turns writes into two reserved 4 KB address windows into SDRAM mode-register-set (MRS) commands. Each window belongs to one chip-select area. The first window starts at 0xFFF84000 and the second starts 0x1000 above it. A word-size write into a window sends the low twelve address bits of the access to the SDRAM address pins as the mode value. The data on the bus is never looked at. The upper external address pins carry zero while the command is on the pins.

Software must program the controller's configuration first, which the block sees through a configuration-done input. It then writes once into the window of each SDRAM area. The block holds the bus ready low after a command until the command-to-command delay has elapsed. That delay is a parameter in clock cycles.

Some accesses hit a window but cannot issue a command: the wrong size, an early write, or an unsupported mode value. These are completed without driving the pins. The last two also set a sticky error flag.

Top module: `sdram_mrs_decoder`

## Requirements
- R1: After reset, bus ready and the error flag are low. Every chip select, both row strobes, both column strobes and the write line are high (inactive). The external address is zero.
- R2: A word write (size code 01) that is accepted at a clock edge issues a command in the cycle after that edge, for exactly one cycle, provided the address falls in window n (base 0xFFF84000 + n*0x1000, window size 0x1000), configuration is done and the mode value is legal. During that cycle only chip select n is low, both row strobes, both column strobes and the write line are low, and the external address equals address bits [11:0].
- R3: While a command is on the pins, every external address bit from bit 12 upward is zero.
- R4: The write data of a window access has no effect on the command or on the mode value driven.
- R5: After a command, bus ready is high for exactly one cycle, TMRD cycles after the command cycle.
- R6: A write to a window with size byte (00) or longword (10) is acknowledged by a one-cycle ready in the cycle after the accepting edge. It drives no command and leaves the error flag unchanged.
- R7: A word write to a window while configuration-done is low is acknowledged in the cycle after the accepting edge and drives no command. It sets the error flag, which stays high until reset.
- R8: A mode value is legal only when burst length bits [2:0] = 000, wrap bit [3] = 0, CAS latency bits [6:4] = 010 or 011, bits [8:7] = 00 and bits [11:10] = 00. Bit 9 selects burst (0) or single (1) writes. A word write with any other value is handled as in R7: acknowledged, no command, error flag set.
- R9: Reads, and writes outside both windows, get no ready and no command from this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Controller configuration has been programmed |
| bus_req | input | 1 | Access strobe, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | 00 byte, 01 word, 10 longword |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_ready | output | 1 | One-cycle completion for a window access |
| mode_err | output | 1 | Sticky error: early or illegal mode write |
| sd_cs_n | output | 2 | Per-area chip select, active low |
| sd_ras_n | output | 2 | Upper and lower row strobes, active low |
| sd_cas_n | output | 2 | Upper and lower column strobes, active low |
| sd_we_n | output | 1 | Write line, active low |
| sd_addr | output | 16 | External address pins |

## Verification
The assertions check on every cycle that ready lasts one cycle, that a command lasts one cycle and selects at most one area, and that the upper address pins are zero. They also check that every command traces back to a configured, word-size write with a legal mode value, and that the error flag never clears. Some behaviour only the bench scenarios can show: which area gets the command, the exact ready latency for each kind of access, that the data has no effect, and that reads and out-of-window writes are never answered.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

  localparam int MODE_W = 12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } bus_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10,
    ST_ACK   = 2'b11
  } seq_state_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_ACK  = 2'b01,
    ACT_ERR  = 2'b10,
    ACT_CMD  = 2'b11
  } req_action_e;

  // Specification view of a legal mode value, used by checks only.
  function automatic logic mode_value_ok(input logic [MODE_W-1:0] v);
    return (v[2:0] == 3'b000) && !v[3] &&
           ((v[6:4] == 3'd2) || (v[6:4] == 3'd3)) &&
           (v[8:7] == 2'b00) && (v[11:10] == 2'b00);
  endfunction

endpackage

// File: rtl/mrs_window_decode.sv
module mrs_window_decode
  import sdram_mrs_pkg::*;
#(
  parameter int                     NUM_AREAS  = 2,
  parameter int                     BUS_ADDR_W = 32,
  parameter logic [BUS_ADDR_W-1:0]  WIN_BASE   = 32'hFFF8_4000,
  parameter int                     WIN_STRIDE = 32'h0000_1000
) (
  input  logic [BUS_ADDR_W-1:0] addr_i,
  output logic [NUM_AREAS-1:0]  hit_o,
  output logic [MODE_W-1:0]     offset_o
);

  localparam int TAG_W = BUS_ADDR_W - MODE_W;

  logic [TAG_W-1:0] addr_tag;

  assign addr_tag = addr_i[BUS_ADDR_W-1:MODE_W];
  assign offset_o = addr_i[MODE_W-1:0];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_win
    localparam logic [BUS_ADDR_W-1:0] AREA_BASE =
      WIN_BASE + BUS_ADDR_W'(WIN_STRIDE * g);
    localparam logic [TAG_W-1:0] AREA_TAG = AREA_BASE[BUS_ADDR_W-1:MODE_W];
    assign hit_o[g] = (addr_tag == AREA_TAG);
  end

  // R2: windows never overlap, so at most one area matches
  always_comb begin
    assert_window_unique_R2: assert ($onehot0(hit_o))
      else $error("two windows matched one address");
  end

endmodule

// File: rtl/mrs_mode_check.sv
module mrs_mode_check
  import sdram_mrs_pkg::*;
(
  input  logic [MODE_W-1:0] value_i,
  output logic              legal_o
);

  logic [2:0] burst_len;
  logic       wrap_interleave;
  logic [2:0] cas_lat;
  logic [1:0] test_bits;
  logic       write_single;
  logic [1:0] rsvd_bits;
  logic       bl_ok;
  logic       cl_ok;
  logic       misc_ok;
  logic       mode_unused;

  assign burst_len       = value_i[2:0];
  assign wrap_interleave = value_i[3];
  assign cas_lat         = value_i[6:4];
  assign test_bits       = value_i[8:7];
  assign write_single    = value_i[9];
  assign rsvd_bits       = value_i[11:10];

  // Either write mode is accepted; the bit is passed through untouched.
  assign mode_unused = write_single;

  always_comb begin
    bl_ok   = (burst_len == 3'b000) && !wrap_interleave;
    cl_ok   = 1'b0;
    case (cas_lat)
      3'd2:    cl_ok = 1'b1;
      3'd3:    cl_ok = 1'b1;
      default: cl_ok = 1'b0;
    endcase
    misc_ok = (test_bits == 2'b00) && (rsvd_bits == 2'b00);
  end

  assign legal_o = bl_ok && cl_ok && misc_ok;

endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import sdram_mrs_pkg::*;
#(
  parameter int NUM_AREAS = 2,
  parameter int TMRD      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic                 write_i,
  input  logic [1:0]           size_i,
  input  logic [NUM_AREAS-1:0] hit_i,
  input  logic                 cfg_done_i,
  input  logic                 legal_i,
  output logic                 issue_o,
  output logic                 ready_o,
  output logic                 err_o
);

  localparam int CNT_W = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMRD - 1);

  seq_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             err_q, err_n;
  logic             err_en;
  req_action_e      action;

  // Classify the access presented in idle.
  always_comb begin
    action = ACT_NONE;
    if (req_i && write_i && (|hit_i)) begin
      if (bus_size_e'(size_i) != SZ_WORD) action = ACT_ACK;
      else if (!cfg_done_i || !legal_i)   action = ACT_ERR;
      else                                action = ACT_CMD;
    end
  end

  // Next-state process.
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    err_n   = err_q;
    err_en  = 1'b0;
    issue_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        case (action)
          ACT_ACK: state_n = ST_ACK;
          ACT_ERR: begin
            state_n = ST_ACK;
            err_n   = 1'b1;
            err_en  = 1'b1;
          end
          ACT_CMD: begin
            state_n = ST_ISSUE;
            cnt_n   = CNT_LOAD;
            cnt_en  = 1'b1;
            issue_o = 1'b1;
          end
          default: state_n = ST_IDLE;
        endcase
      end
      ST_ISSUE, ST_WAIT: begin
        if (cnt_q == '0) begin
          state_n = ST_ACK;
        end else begin
          state_n = ST_WAIT;
          cnt_n   = cnt_q - 1'b1;
          cnt_en  = 1'b1;
        end
      end
      ST_ACK:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (err_en) err_q <= err_n;
    end
  end

  assign ready_o = (state_q == ST_ACK);
  assign err_o   = err_q;

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o)
    else $error("ready held longer than one cycle");

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o)
    else $error("error flag cleared without reset");

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD)
    else $error("delay counter out of range");

  assert_wait_to_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && cnt_q == '0) |=> ready_o)
    else $error("delay expired without ready");

endmodule

// File: rtl/mrs_cmd_drive.sv
module mrs_cmd_drive
  import sdram_mrs_pkg::*;
#(
  parameter int NUM_AREAS  = 2,
  parameter int EXT_ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_i,
  input  logic [NUM_AREAS-1:0]  hit_i,
  input  logic [MODE_W-1:0]     value_i,
  output logic [NUM_AREAS-1:0]  cs_n_o,
  output logic [1:0]            ras_n_o,
  output logic [1:0]            cas_n_o,
  output logic                  we_n_o,
  output logic [EXT_ADDR_W-1:0] addr_o,
  output logic                  active_o
);

  localparam int UPPER_W = EXT_ADDR_W - MODE_W;

  logic                  cmd_q, cmd_n;
  logic [NUM_AREAS-1:0]  area_q, area_n;
  logic [EXT_ADDR_W-1:0] addr_q, addr_n;
  logic                  load_en;

  // Next-state process: load on issue, clear the cycle after.
  always_comb begin
    load_en = issue_i || cmd_q;
    cmd_n   = issue_i;
    area_n  = issue_i ? hit_i : '0;
    addr_n  = issue_i ? {{UPPER_W{1'b0}}, value_i} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      area_q <= '0;
      addr_q <= '0;
    end else if (load_en) begin
      cmd_q  <= cmd_n;
      area_q <= area_n;
      addr_q <= addr_n;
    end
  end

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
    assign cs_n_o[g] = !(cmd_q && area_q[g]);
  end

  assign ras_n_o  = {2{!cmd_q}};
  assign cas_n_o  = {2{!cmd_q}};
  assign we_n_o   = !cmd_q;
  assign addr_o   = addr_q;
  assign active_o = cmd_q;

  assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q |=> !cmd_q)
    else $error("command held longer than one cycle");

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o))
    else $error("more than one chip select active");

  assert_cs_with_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q |-> $countones(~cs_n_o) == 1)
    else $error("command without exactly one chip select");

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q |-> addr_o[EXT_ADDR_W-1:MODE_W] == '0)
    else $error("upper address pins not zero during command");

  assert_idle_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q |-> addr_o == '0)
    else $error("address pins driven while idle");

endmodule

// File: rtl/sdram_mrs_decoder.sv
module sdram_mrs_decoder
  import sdram_mrs_pkg::*;
#(
  parameter int                    NUM_AREAS  = 2,
  parameter int                    BUS_ADDR_W = 32,
  parameter int                    BUS_DATA_W = 32,
  parameter int                    EXT_ADDR_W = 16,
  parameter logic [BUS_ADDR_W-1:0] WIN_BASE   = 32'hFFF8_4000,
  parameter int                    WIN_STRIDE = 32'h0000_1000,
  parameter int                    TMRD       = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_done,
  input  logic                  bus_req,
  input  logic                  bus_write,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [1:0]            bus_size,
  input  logic [BUS_DATA_W-1:0] bus_wdata,
  output logic                  bus_ready,
  output logic                  mode_err,
  output logic [NUM_AREAS-1:0]  sd_cs_n,
  output logic [1:0]            sd_ras_n,
  output logic [1:0]            sd_cas_n,
  output logic                  sd_we_n,
  output logic [EXT_ADDR_W-1:0] sd_addr
);

  logic [NUM_AREAS-1:0] hit;
  logic [MODE_W-1:0]    offset;
  logic                 legal;
  logic                 issue;
  logic                 cmd_active;
  logic                 data_unused;

  // Write data carries nothing for a mode write.
  assign data_unused = ^bus_wdata;

  mrs_window_decode #(
    .NUM_AREAS  (NUM_AREAS),
    .BUS_ADDR_W (BUS_ADDR_W),
    .WIN_BASE   (WIN_BASE),
    .WIN_STRIDE (WIN_STRIDE)
  ) u_decode (
    .addr_i   (bus_addr),
    .hit_o    (hit),
    .offset_o (offset)
  );

  mrs_mode_check u_check (
    .value_i (offset),
    .legal_o (legal)
  );

  mrs_seq #(
    .NUM_AREAS (NUM_AREAS),
    .TMRD      (TMRD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (bus_req),
    .write_i    (bus_write),
    .size_i     (bus_size),
    .hit_i      (hit),
    .cfg_done_i (cfg_done),
    .legal_i    (legal),
    .issue_o    (issue),
    .ready_o    (bus_ready),
    .err_o      (mode_err)
  );

  mrs_cmd_drive #(
    .NUM_AREAS  (NUM_AREAS),
    .EXT_ADDR_W (EXT_ADDR_W)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue),
    .hit_i    (hit),
    .value_i  (offset),
    .cs_n_o   (sd_cs_n),
    .ras_n_o  (sd_ras_n),
    .cas_n_o  (sd_cas_n),
    .we_n_o   (sd_we_n),
    .addr_o   (sd_addr),
    .active_o (cmd_active)
  );

  assert_cmd_needs_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_active |-> $past(cfg_done))
    else $error("command issued before configuration");

  assert_cmd_word_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_active |-> $past(bus_size) == SZ_WORD && $past(bus_write))
    else $error("command from a non-word or read access");

  assert_cmd_legal_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_active |-> mode_value_ok(sd_addr[MODE_W-1:0]))
    else $error("illegal mode value on the pins");

  assert_no_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> $past(bus_req))
    else $error("ready without a pending access");

endmodule

// File: tb/sdram_mrs_decoder_tb.sv
module sdram_mrs_decoder_tb;

  localparam int T_MRD = 3;
  localparam logic [31:0] BASE0 = 32'hFFF8_4000;
  localparam logic [31:0] BASE1 = 32'hFFF8_5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_done;
  logic        bus_req;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic        mode_err;
  logic [1:0]  sd_cs_n;
  logic [1:0]  sd_ras_n;
  logic [1:0]  sd_cas_n;
  logic        sd_we_n;
  logic [15:0] sd_addr;

  int checks = 0;
  int failures = 0;
  logic exp_err = 1'b0;

  always #5 clk = ~clk;

  sdram_mrs_decoder #(.TMRD(T_MRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .bus_req(bus_req),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .mode_err(mode_err),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic legal_value(input logic [11:0] v);
    return (v[2:0] == 0) && (v[3] == 0) && (v[6:4] == 2 || v[6:4] == 3) &&
           (v[8:7] == 0) && (v[11:10] == 0);
  endfunction

  // 0 = no response, 1 = plain ack, 2 = ack with error, 3 = command
  function automatic int classify(input logic [31:0] a, input logic [1:0] sz,
                                  input logic wr, input logic cfg);
    if (!wr) return 0;
    if (a[31:12] != BASE0[31:12] && a[31:12] != BASE1[31:12]) return 0;
    if (sz != 2'b01) return 1;
    if (!cfg || !legal_value(a[11:0])) return 2;
    return 3;
  endfunction

  task automatic run_access(input logic [31:0] a, input logic [1:0] sz,
                            input logic wr, input logic [31:0] d,
                            output logic [15:0] got_addr);
    int kind;
    int rdy_idx = -1;
    int cmd_cnt = 0;
    int cmd_idx = -1;
    logic [1:0] cs_seen = 2'b11;
    logic strobes_ok = 1'b0;
    int area;
    kind = classify(a, sz, wr, cfg_done);
    area = (a[31:12] == BASE1[31:12]) ? 1 : 0;
    got_addr = 16'h0;
    bus_req = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    for (int i = 0; i < T_MRD + 4; i++) begin
      @(negedge clk);
      if (sd_cs_n != 2'b11 || sd_we_n == 1'b0) begin
        cmd_cnt++;
        cmd_idx = i;
        cs_seen = sd_cs_n;
        got_addr = sd_addr;
        strobes_ok = (sd_ras_n == 2'b00) && (sd_cas_n == 2'b00) && !sd_we_n;
      end
      if (bus_ready && rdy_idx < 0) begin
        rdy_idx = i;
        bus_req = 1'b0;
        break;
      end
    end
    bus_req = 1'b0;
    case (kind)
      0: begin
        check(rdy_idx == -1, "R9 no ready", rdy_idx, -1);
        check(cmd_cnt == 0, "R9 no command", cmd_cnt, 0);
      end
      1: begin
        check(rdy_idx == 0, "R6 ready latency", rdy_idx, 0);
        check(cmd_cnt == 0, "R6 no command", cmd_cnt, 0);
        check(mode_err == exp_err, "R6 error unchanged", mode_err, exp_err);
      end
      2: begin
        exp_err = 1'b1;
        check(rdy_idx == 0, "R7/R8 ready latency", rdy_idx, 0);
        check(cmd_cnt == 0, "R7/R8 no command", cmd_cnt, 0);
        check(mode_err == 1'b1, "R7/R8 error set", mode_err, 1);
      end
      default: begin
        check(cmd_cnt == 1 && cmd_idx == 0, "R2 single command cycle", cmd_idx, 0);
        check(cs_seen == ~(2'b01 << area), "R2 chip select", cs_seen, ~(2'b01 << area));
        check(strobes_ok, "R2 strobes low", strobes_ok, 1);
        check(got_addr[11:0] == a[11:0], "R2 mode value", got_addr[11:0], a[11:0]);
        check(got_addr[15:12] == 4'h0, "R3 upper pins zero", got_addr[15:12], 0);
        check(rdy_idx == T_MRD, "R5 ready after delay", rdy_idx, T_MRD);
        check(mode_err == exp_err, "R2 error unchanged", mode_err, exp_err);
      end
    endcase
    @(negedge clk);
    if (kind != 0)
      check(bus_ready == 1'b0, "R5 ready one cycle", bus_ready, 0);
  endtask

  initial begin
    #(10 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] a1;
    logic [15:0] a2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_done = 1'b0; bus_req = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_size = 2'b01; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check(bus_ready == 0 && mode_err == 0, "R1 ready/err", {bus_ready, mode_err}, 0);
    check(sd_cs_n == 2'b11 && sd_ras_n == 2'b11 && sd_cas_n == 2'b11 && sd_we_n,
          "R1 strobes idle", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7'h7f);
    check(sd_addr == 0, "R1 address zero", sd_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 before configuration: size mismatch does not set the error
    run_access(BASE0 + 32'h030, 2'b00, 1'b1, 32'h0, a1);
    // R7: legal value before configuration
    run_access(BASE0 + 32'h020, 2'b01, 1'b1, 32'h0, a1);
    cfg_done = 1'b1;
    // R2/R5 both areas, both CAS latencies, both write modes
    run_access(BASE0 + 32'h020, 2'b01, 1'b1, 32'h1234_5678, a1);
    run_access(BASE1 + 32'h230, 2'b01, 1'b1, 32'hFFFF_FFFF, a1);
    // R4: same address, different data, same mode value
    run_access(BASE1 + 32'h030, 2'b01, 1'b1, 32'h0000_0000, a1);
    run_access(BASE1 + 32'h030, 2'b01, 1'b1, 32'hA5A5_5A5A, a2);
    check(a1 == a2 && a1 == 16'h0030, "R4 data ignored", a2, a1);
    // R8: illegal values (CAS 1, burst 4, test bits, top bits)
    run_access(BASE0 + 32'h010, 2'b01, 1'b1, 32'h0, a1);
    run_access(BASE0 + 32'h022, 2'b01, 1'b1, 32'h0, a1);
    run_access(BASE1 + 32'h0A0, 2'b01, 1'b1, 32'h0, a1);
    run_access(BASE1 + 32'hC20, 2'b01, 1'b1, 32'h0, a1);
    // R6 longword, R9 read and outside window
    run_access(BASE1 + 32'h020, 2'b10, 1'b1, 32'h0, a1);
    run_access(BASE0 + 32'h020, 2'b01, 1'b0, 32'h0, a1);
    run_access(32'hFFF8_6020, 2'b01, 1'b1, 32'h0, a1);
    run_access(32'hFFF8_3030, 2'b01, 1'b1, 32'h0, a1);

    for (int n = 0; n < 200; n++) begin
      logic [31:0] a;
      logic [11:0] off;
      logic [1:0]  sz;
      int pick;
      pick = $urandom_range(0, 3);
      case (pick)
        0: off = 12'h020;
        1: off = 12'h030;
        2: off = 12'h220;
        default: off = 12'($urandom_range(0, 4095));
      endcase
      case ($urandom_range(0, 4))
        0, 1: a = BASE0 + {20'h0, off};
        2, 3: a = BASE1 + {20'h0, off};
        default: a = {$urandom_range(0, 32'hFFFF_F) , off};
      endcase
      sz = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 2)) : 2'b01;
      run_access(a, sz, ($urandom_range(0, 9) != 0), $urandom, a1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule